// File: doc/BRIEF.md
# Sub-blocked associative instruction cache

This block is the instruction store beside a pipelined processor's fetch stage. It holds 512 instruction words in 8 large blocks of 64 words. Each block has one tag and can sit in any of the 8 ways. Within a block, validity is tracked for each 2-word sub-block, so one tag covers a large span of code while a miss moves only two words. The fetch stage presents a word address with a request. In the same cycle the cache answers with the instruction and a hit flag, or it raises a stall.

On a miss the cache asks an external combined cache for the two words of the addressed sub-block and installs them one beat at a time, in ascending order. If the tag is already resident, only that sub-block is filled and the block keeps its other words. If the tag is not resident, a victim way is chosen in round-robin order. The victim takes the new tag, all of its sub-block valid bits are cleared, and then the requested sub-block is filled. While a refill is outstanding, fetch stalls and no hit is reported. A one-cycle flush drops every block and every sub-block.

Top module: `icache_sb`

## Requirements
- R1: When the requested word is resident and no refill is outstanding, `fetch_hit_o` is 1 and `fetch_data_o` holds that word in the same cycle as the request, with `fetch_stall_o` 0.
- R2: The block is fully associative over 8 ways. Words from 8 different tags (tag = address bits [15:6]) can be resident at once, and all of them hit with no refill.
- R3: A miss raises `refill_req_o` with `refill_addr_o` set to the requested address with bit 0 cleared. The cache accepts exactly two beats, for the even word and then the odd word. After the refill completes, both words hit.
- R4: A fetch whose tag is resident but whose 2-word sub-block (address bits [5:1]) is not valid refills only that sub-block. Previously valid sub-blocks of the same block keep hitting.
- R5: Once raised, `refill_req_o` stays 1 and `refill_addr_o` stays constant until the second beat is accepted.
- R6: While a fetch is requested and does not hit, `fetch_stall_o` is 1. While `refill_req_o` is 1, `fetch_hit_o` is 0.
- R7: On a tag miss, the victim way is taken round-robin, starting at way 0 after reset. The evicted tag misses afterwards, and the other resident tags still hit.
- R8: A cycle with `flush_i` high invalidates every block, so the first fetch after it misses and is refilled.
- R9: If `flush_i` coincides with the second refill beat, the filled sub-block is not marked valid, and the same fetch issues a new refill.
- R10: After reset, with no request pending, `fetch_hit_o`, `fetch_stall_o` and `refill_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all blocks |
| fetch_req_i | input | 1 | Fetch request |
| fetch_addr_i | input | 16 | Fetch word address |
| fetch_data_o | output | 32 | Instruction word, valid with hit |
| fetch_hit_o | output | 1 | Requested word returned this cycle |
| fetch_stall_o | output | 1 | Request not served this cycle |
| refill_req_o | output | 1 | Two-word refill outstanding |
| refill_addr_o | output | 16 | Even word address of the sub-block |
| refill_valid_i | input | 1 | Refill beat present |
| refill_data_i | input | 32 | Refill beat data |

## Verification
The flush and the completion of a refill can fall in the same cycle. The two contend for the same valid bit, one setting it and the other clearing everything. The bench's external-cache responder raises the flush on the exact negative edge at which it drives the second beat, so the coincidence is deterministic. The outcome is judged at the ports: the held fetch must not hit, and exactly one further two-word refill must appear for that address before the word is returned with the correct data.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_FILL
  } fill_state_e;
endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int BLOCKS = 8,
  parameter int SUBS   = 32,
  parameter int TAG_W  = 10,
  parameter int WAY_W  = 3,
  parameter int SUB_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic [SUB_W-1:0] lk_sub_i,
  output logic [WAY_W-1:0] match_way_o,
  output logic             tag_hit_o,
  output logic             sub_vld_o,
  input  logic             alloc_i,
  input  logic [TAG_W-1:0] alloc_tag_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             fill_set_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic [SUB_W-1:0] fill_sub_i
);

  logic [TAG_W-1:0] tag_q     [BLOCKS];
  logic [SUBS-1:0]  sub_vld_q [BLOCKS];
  logic [BLOCKS-1:0] blk_vld_q;
  logic [WAY_W-1:0] rr_q;
  logic [BLOCKS-1:0] match_vec;

  for (genvar g = 0; g < BLOCKS; g++) begin : g_cmp
    assign match_vec[g] = blk_vld_q[g] && (tag_q[g] == lk_tag_i);
  end

  always_comb begin
    match_way_o = '0;
    for (int w = BLOCKS - 1; w >= 0; w--) begin
      if (match_vec[w]) match_way_o = WAY_W'(w);
    end
  end

  assign tag_hit_o = |match_vec;
  assign sub_vld_o = sub_vld_q[match_way_o][lk_sub_i];
  assign victim_o  = rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_vld_q <= '0;
      rr_q      <= '0;
      for (int w = 0; w < BLOCKS; w++) begin
        tag_q[w]     <= '0;
        sub_vld_q[w] <= '0;
      end
    end else if (flush_i) begin
      blk_vld_q <= '0;
      for (int w = 0; w < BLOCKS; w++) sub_vld_q[w] <= '0;
    end else begin
      if (alloc_i) begin
        tag_q[rr_q]     <= alloc_tag_i;
        blk_vld_q[rr_q] <= 1'b1;
        sub_vld_q[rr_q] <= '0;
        rr_q <= (rr_q == WAY_W'(BLOCKS - 1)) ? '0 : rr_q + WAY_W'(1);
      end
      if (fill_set_i) sub_vld_q[fill_way_i][fill_sub_i] <= 1'b1;
    end
  end

  AST_ONE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec)) else $error("duplicate resident tag"); // R2

  AST_ALLOC_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !tag_hit_o) else $error("allocation of resident tag"); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !tag_hit_o) else $error("tag survives flush"); // R8

endmodule

// File: rtl/icache_data.sv
module icache_data #(
  parameter int DEPTH  = 512,
  parameter int IDX_W  = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 6,
  parameter int BEAT_W = 1,
  parameter int SUB_W  = 5,
  parameter int WAY_W  = 3,
  parameter int IDX_W  = 9,
  parameter int SUB_WORDS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              tag_hit_i,
  input  logic              sub_vld_i,
  input  logic [WAY_W-1:0]  match_way_i,
  input  logic [WAY_W-1:0]  victim_i,
  output logic              hit_o,
  output logic              alloc_o,
  output logic              fill_set_o,
  output logic [WAY_W-1:0]  fill_way_o,
  output logic [SUB_W-1:0]  fill_sub_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              refill_req_o,
  output logic [ADDR_W-1:0] refill_addr_o,
  input  logic              refill_valid_i,
  input  logic [DATA_W-1:0] refill_data_i
);

  fill_state_e       state_q;
  logic [WAY_W-1:0]  way_q;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic              idle, miss, last_beat;

  assign idle      = (state_q == ST_IDLE);
  assign miss      = idle && fetch_req_i && !(tag_hit_i && sub_vld_i) && !flush_i;
  assign last_beat = (beat_q == BEAT_W'(SUB_WORDS - 1));

  assign hit_o      = idle && fetch_req_i && tag_hit_i && sub_vld_i;
  assign alloc_o    = miss && !tag_hit_i;
  assign we_o       = !idle && refill_valid_i;
  // flush in the closing beat wins over marking the sub-block valid
  assign fill_set_o = we_o && last_beat && !flush_i;
  assign fill_way_o = way_q;
  assign fill_sub_o = base_q[OFF_W-1:BEAT_W];
  assign waddr_o    = {way_q, base_q[OFF_W-1:BEAT_W], beat_q};
  assign wdata_o    = refill_data_i;

  assign refill_req_o  = !idle;
  assign refill_addr_o = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      way_q   <= '0;
      base_q  <= '0;
      beat_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (miss) begin
            state_q <= ST_FILL;
            way_q   <= tag_hit_i ? match_way_i : victim_i;
            base_q  <= {fetch_addr_i[ADDR_W-1:BEAT_W], {BEAT_W{1'b0}}};
            beat_q  <= '0;
          end
        end
        default: begin
          if (refill_valid_i) begin
            beat_q <= beat_q + BEAT_W'(1);
            if (last_beat) state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_req_o && !(refill_valid_i && last_beat)) |=>
      (refill_req_o && $stable(refill_addr_o))) else $error("refill request dropped"); // R5

  AST_REQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_req_o |-> (refill_addr_o[BEAT_W-1:0] == '0)) else $error("unaligned refill"); // R3

  AST_NO_HIT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_req_o |-> !hit_o) else $error("hit during refill"); // R6

  AST_ONE_BEAT_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_o && we_o)) else $error("allocate while filling"); // R7

endmodule

// File: rtl/icache_sb.sv
module icache_sb #(
  parameter int WORDS     = 512,
  parameter int BLOCKS    = 8,
  parameter int SUB_WORDS = 2,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              fetch_hit_o,
  output logic              fetch_stall_o,
  output logic              refill_req_o,
  output logic [ADDR_W-1:0] refill_addr_o,
  input  logic              refill_valid_i,
  input  logic [DATA_W-1:0] refill_data_i
);

  localparam int BLOCK_WORDS = WORDS / BLOCKS;
  localparam int OFF_W  = $clog2(BLOCK_WORDS);
  localparam int BEAT_W = $clog2(SUB_WORDS);
  localparam int SUB_W  = OFF_W - BEAT_W;
  localparam int SUBS   = BLOCK_WORDS / SUB_WORDS;
  localparam int WAY_W  = $clog2(BLOCKS);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int IDX_W  = WAY_W + OFF_W;

  logic [WAY_W-1:0]  match_way, victim, fill_way;
  logic              tag_hit, sub_vld, alloc, fill_set, we, hit;
  logic [SUB_W-1:0]  fill_sub;
  logic [IDX_W-1:0]  waddr;
  logic [DATA_W-1:0] wdata;
  logic [TAG_W-1:0]  lk_tag;

  assign lk_tag = fetch_addr_i[ADDR_W-1:OFF_W];

  icache_tags #(
    .BLOCKS(BLOCKS), .SUBS(SUBS), .TAG_W(TAG_W), .WAY_W(WAY_W), .SUB_W(SUB_W)
  ) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .lk_tag_i    (lk_tag),
    .lk_sub_i    (fetch_addr_i[OFF_W-1:BEAT_W]),
    .match_way_o (match_way),
    .tag_hit_o   (tag_hit),
    .sub_vld_o   (sub_vld),
    .alloc_i     (alloc),
    .alloc_tag_i (lk_tag),
    .victim_o    (victim),
    .fill_set_i  (fill_set),
    .fill_way_i  (fill_way),
    .fill_sub_i  (fill_sub)
  );

  icache_data #(
    .DEPTH(WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W)
  ) u_data (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i ({match_way, fetch_addr_i[OFF_W-1:0]}),
    .rdata_o (fetch_data_o)
  );

  icache_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .BEAT_W(BEAT_W),
    .SUB_W(SUB_W), .WAY_W(WAY_W), .IDX_W(IDX_W), .SUB_WORDS(SUB_WORDS)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flush_i        (flush_i),
    .fetch_req_i    (fetch_req_i),
    .fetch_addr_i   (fetch_addr_i),
    .tag_hit_i      (tag_hit),
    .sub_vld_i      (sub_vld),
    .match_way_i    (match_way),
    .victim_i       (victim),
    .hit_o          (hit),
    .alloc_o        (alloc),
    .fill_set_o     (fill_set),
    .fill_way_o     (fill_way),
    .fill_sub_o     (fill_sub),
    .we_o           (we),
    .waddr_o        (waddr),
    .wdata_o        (wdata),
    .refill_req_o   (refill_req_o),
    .refill_addr_o  (refill_addr_o),
    .refill_valid_i (refill_valid_i),
    .refill_data_i  (refill_data_i)
  );

  assign fetch_hit_o   = hit;
  assign fetch_stall_o = fetch_req_i && !hit;

  AST_HIT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_hit_o |-> fetch_req_i) else $error("hit without request"); // R1

  AST_MISS_RAISES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_stall_o && !refill_req_o && !flush_i) |=> refill_req_o) else $error("miss without refill"); // R3

endmodule

// File: tb/icache_sb_bench.sv
`timescale 1ns/1ps
module icache_sb_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_tb = 1'b0;
  logic        resp_flush = 1'b0;
  logic        flush_w;
  logic        fetch_req_i = 1'b0;
  logic [15:0] fetch_addr_i = '0;
  logic [31:0] fetch_data_o;
  logic        fetch_hit_o, fetch_stall_o, refill_req_o;
  logic [15:0] refill_addr_o;
  logic        refill_valid_i = 1'b0;
  logic [31:0] refill_data_i = '0;

  int checks = 0;
  int errors = 0;
  int refill_cnt = 0;
  int addr_err = 0;
  int stall_err = 0;
  bit flush_on_last = 1'b0;
  logic [15:0] last_req_addr = '0;

  assign flush_w = flush_tb | resp_flush;

  always #10 clk = ~clk;

  icache_sb u_icache_sb (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .flush_i        (flush_w),
    .fetch_req_i    (fetch_req_i),
    .fetch_addr_i   (fetch_addr_i),
    .fetch_data_o   (fetch_data_o),
    .fetch_hit_o    (fetch_hit_o),
    .fetch_stall_o  (fetch_stall_o),
    .refill_req_o   (refill_req_o),
    .refill_addr_o  (refill_addr_o),
    .refill_valid_i (refill_valid_i),
    .refill_data_i  (refill_data_i)
  );

  function automatic logic [31:0] model(logic [15:0] a);
    return {a ^ 16'hC35A, a};
  endfunction

  function automatic logic [15:0] mk(int tag, int off);
    return 16'((tag << 6) | off);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // external cache: one wait cycle, then two ascending beats
  initial begin
    int wait_c;
    int beat;
    logic [15:0] cur;
    wait_c = 0;
    beat = 0;
    cur = '0;
    forever begin
      @(negedge clk);
      refill_valid_i = 1'b0;
      resp_flush = 1'b0;
      if (refill_req_o) begin
        if (wait_c == 0) begin
          wait_c = 1;
          cur = refill_addr_o;
        end else begin
          if (refill_addr_o != cur) addr_err++;
          refill_valid_i = 1'b1;
          refill_data_i = model(cur + 16'(beat));
          if (beat == 0) begin
            refill_cnt++;
            last_req_addr = cur;
          end
          if (beat == 1 && flush_on_last) begin
            resp_flush = 1'b1;
            flush_on_last = 1'b0;
          end
          beat++;
        end
      end else begin
        wait_c = 0;
        beat = 0;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    fetch_req_i = 1'b0;
    flush_tb = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic fetch(input logic [15:0] a, output logic [31:0] got, output int waits);
    bit done;
    @(negedge clk);
    fetch_req_i = 1'b1;
    fetch_addr_i = a;
    waits = 0;
    done = 1'b0;
    got = '0;
    while (!done && waits < 40) begin
      #1;
      if (fetch_hit_o) begin
        if (refill_req_o || fetch_stall_o) stall_err++;
        got = fetch_data_o;
        done = 1'b1;
      end else begin
        if (!fetch_stall_o) stall_err++;
        @(negedge clk);
        waits++;
      end
    end
    fetch_req_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(!fetch_hit_o && !refill_req_o && !fetch_stall_o, "R10 idle after reset",
          {fetch_hit_o, refill_req_o, fetch_stall_o}, 0);
  endtask

  task automatic t_cold_miss();
    logic [31:0] d;
    int w, c0;
    do_reset();
    c0 = refill_cnt;
    fetch(mk(5, 6), d, w);
    check(d == model(mk(5, 6)) && w > 0, "R3 cold miss data", d, model(mk(5, 6)));
    check(refill_cnt - c0 == 1 && last_req_addr == mk(5, 6), "R3 refill address",
          last_req_addr, mk(5, 6));
    fetch(mk(5, 7), d, w);
    check(d == model(mk(5, 7)) && w == 0, "R1 partner word hits at once", w, 0);
    fetch(mk(5, 6), d, w);
    check(d == model(mk(5, 6)) && w == 0, "R1 repeat hit", d, model(mk(5, 6)));
    fetch(mk(5, 8), d, w);
    check(w > 0 && refill_cnt - c0 == 2, "R3 only two words filled", refill_cnt - c0, 2);
  endtask

  task automatic t_odd_first();
    logic [31:0] d;
    int w;
    do_reset();
    fetch(mk(9, 13), d, w);
    check(last_req_addr == mk(9, 12) && d == model(mk(9, 13)), "R3 odd miss aligned",
          last_req_addr, mk(9, 12));
    fetch(mk(9, 12), d, w);
    check(w == 0 && d == model(mk(9, 12)), "R3 even word installed", d, model(mk(9, 12)));
  endtask

  task automatic t_assoc_victim();
    logic [31:0] d;
    int w, c0, bad;
    do_reset();
    for (int t = 0; t < 8; t++) fetch(mk(t * 11 + 1, 4), d, w);
    c0 = refill_cnt;
    bad = 0;
    for (int t = 0; t < 8; t++) begin
      fetch(mk(t * 11 + 1, 4), d, w);
      if (w != 0 || d != model(mk(t * 11 + 1, 4))) bad++;
    end
    check(bad == 0 && refill_cnt == c0, "R2 eight tags resident", bad, 0);
    fetch(mk(500, 4), d, w);  // evicts way 0 (first tag)
    fetch(mk(1, 4), d, w);    // first tag misses, evicts way 1
    check(w > 0, "R7 oldest way evicted", w, 1);
    fetch(mk(23, 4), d, w);   // third tag still in way 2
    check(w == 0 && d == model(mk(23, 4)), "R7 untouched way hits", w, 0);
    fetch(mk(12, 4), d, w);   // second tag was evicted
    check(w > 0, "R7 second victim in order", w, 1);
    fetch(mk(500, 4), d, w);
    check(w == 0 && d == model(mk(500, 4)), "R7 new tag kept", w, 0);
  endtask

  task automatic t_sub_miss();
    logic [31:0] d;
    int w, c0;
    do_reset();
    fetch(mk(3, 0), d, w);
    c0 = refill_cnt;
    fetch(mk(3, 20), d, w);
    check(w > 0 && d == model(mk(3, 20)) && refill_cnt - c0 == 1, "R4 sub-block refill",
          refill_cnt - c0, 1);
    check(last_req_addr == mk(3, 20), "R4 sub-block address", last_req_addr, mk(3, 20));
    fetch(mk(3, 1), d, w);
    check(w == 0 && d == model(mk(3, 1)), "R4 sibling sub-block kept", w, 0);
  endtask

  task automatic t_flush();
    logic [31:0] d;
    int w;
    do_reset();
    fetch(mk(7, 2), d, w);
    fetch(mk(8, 2), d, w);
    @(negedge clk);
    flush_tb = 1'b1;
    @(negedge clk);
    flush_tb = 1'b0;
    fetch_req_i = 1'b1;
    fetch_addr_i = mk(8, 2);
    #1;
    check(!fetch_hit_o && fetch_stall_o, "R8 no hit after flush", fetch_hit_o, 0);
    fetch_req_i = 1'b0;
    fetch(mk(7, 2), d, w);
    check(w > 0 && d == model(mk(7, 2)), "R8 refetch after flush", w, 1);
  endtask

  task automatic t_flush_last();
    logic [31:0] d;
    int w, c0;
    do_reset();
    flush_on_last = 1'b1;
    c0 = refill_cnt;
    fetch(mk(40, 30), d, w);
    check(refill_cnt - c0 == 2, "R9 flush on final beat forces refetch", refill_cnt - c0, 2);
    check(d == model(mk(40, 30)), "R9 data after second refill", d, model(mk(40, 30)));
  endtask

  task automatic t_handshake();
    check(addr_err == 0, "R5 refill address held", addr_err, 0);
    check(stall_err == 0, "R6 stall and hit consistent", stall_err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_cold_miss();
    t_odd_first();
    t_assoc_victim();
    t_sub_miss();
    t_flush();
    t_flush_last();
    t_handshake();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule